// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one host request into the full cycle sequence that an 8-bit asynchronous NAND flash device expects. The host presents an operation code, a three-byte row (page) address, a two-byte column address and a transfer length. The block then drives chip enable, the command and address latch enables, the write and read strobes and the I/O bus. It feeds write bytes from a host stream, returns read bytes one at a time, and waits on the device's ready/busy line after the confirm command of the operations that need it.

Each bus cycle has three parts, and each part's length is set by a configuration count: a latch/data setup part, a strobe-low part and a hold part. Completion of a ready wait depends on a sticky flag. The flag is set when the synchronised ready/busy line goes from busy to ready, and the host clears it by pulsing a clear input before it issues a command. If the flag does not appear within a programmable number of cycles, the operation ends with an error. A one-cycle done pulse, qualified by an error bit, ends every accepted request.

Top module: `nand_seq`

## Requirements
- R1: Page read (op 0) issues command 0x00, then five address bytes in the order column low, column high, row bits 7:0, row bits 15:8, row bits 23:16, then command 0x30. It then waits for ready and reads req_len+1 bytes, each one presented on rdata with a one-cycle rdata_valid.
- R2: Page program (op 1) issues 0x80, then the same five address bytes, then req_len+1 data bytes taken in order from wdata (each one acknowledged by a wdata_take pulse), then 0x10, then waits for ready.
- R3: Block erase (op 2) issues 0x60, then only the three row bytes (low first), then 0xD0, then waits for ready.
- R4: Status read (op 3) issues 0x70 and reads exactly one byte. That byte appears on status, and err at done equals its bit 0 (bit 6 is the device's ready bit).
- R5: ID read (op 4) issues 0x90, one address byte 0x00, then reads req_len+1 bytes. Reset (op 5) issues 0xFF and then waits for ready.
- R6: Random column read (op 6) issues 0x05, the two column bytes (low first) and 0xE0, then reads req_len+1 bytes without a ready wait.
- R7: On every bus cycle, nf_we_n (for command, address and write data) or nf_re_n (for read data) stays low for cfg_strobe+1 clock cycles. Latch and data lines become valid cfg_setup+1 cycles before the strobe falls and stay valid for cfg_hold+1 cycles after it rises. nf_cle and nf_ale are never high together, and the two strobes are never low together.
- R8: nf_ce_n is high while idle. It is low from the cycle after a request is accepted through the done cycle, and done is a single-cycle pulse after which busy is low.
- R9: rb_flag sets on a busy-to-ready transition of nf_rb_n and clears when rb_clr is pulsed. A ready wait ends only once rb_flag is set.
- R10: If rb_flag is not set within cfg_timeout+1 cycles of the start of a ready wait, the operation ends with done and err=1, and no data cycles follow.
- R11: nf_io_oe is high only during command, address and write-data cycles. It is never high while nf_re_n is low.
- R12: A request presented while busy is ignored. Op code 7 ends at once with done and err=1 and drives no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_op | input | 3 | Operation code (see R1 to R6, R12) |
| req_row | input | 24 | Row (page) address |
| req_col | input | 16 | Column address |
| req_len | input | LW | Data byte count minus one |
| wdata | input | 8 | Write byte for program |
| wdata_take | output | 1 | Pulse: current wdata byte consumed |
| rdata | output | 8 | Read byte |
| rdata_valid | output | 1 | Pulse: rdata holds a new byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error, valid with done |
| status | output | 8 | Last status byte read |
| cfg_setup | input | TW | Setup part length minus one |
| cfg_strobe | input | TW | Strobe-low length minus one |
| cfg_hold | input | TW | Hold part length minus one |
| cfg_timeout | input | TOW | Ready-wait limit in cycles minus one |
| rb_clr | input | 1 | Clear pulse for rb_flag |
| rb_flag | output | 1 | Sticky busy-to-ready flag |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | I/O bus output value |
| nf_io_oe | output | 1 | I/O bus output enable |
| nf_io_in | input | 8 | I/O bus input value |
| nf_rb_n | input | 1 | Ready (1) / busy (0) from the device |

## Verification
The hardest situation to reach is a ready wait that never finishes, which the R10 timeout covers. A well-behaved device always releases the busy line, so the bench's flash model has a switch that holds ready/busy low after a confirm command. With the switch on, the bench runs a page read, shows that the error ends it without any read strobe, and then releases the line so that the stale flag can be cleared. A second case that is awkward to reach is a request arriving during a long busy wait. The bench lengthens the model's busy time and injects a status request partway through a reset, then shows that no 0x70 command reached the bus.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int TW  = 4,
  parameter int LW  = 12,
  parameter int TOW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [2:0]     req_op,
  input  logic [23:0]    req_row,
  input  logic [15:0]    req_col,
  input  logic [LW-1:0]  req_len,
  input  logic [7:0]     wdata,
  output logic           wdata_take,
  output logic [7:0]     rdata,
  output logic           rdata_valid,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [7:0]     status,
  input  logic [TW-1:0]  cfg_setup,
  input  logic [TW-1:0]  cfg_strobe,
  input  logic [TW-1:0]  cfg_hold,
  input  logic [TOW-1:0] cfg_timeout,
  input  logic           rb_clr,
  output logic           rb_flag,
  output logic           nf_ce_n,
  output logic           nf_cle,
  output logic           nf_ale,
  output logic           nf_we_n,
  output logic           nf_re_n,
  output logic [7:0]     nf_io_out,
  output logic           nf_io_oe,
  input  logic [7:0]     nf_io_in,
  input  logic           nf_rb_n
);

  localparam logic [2:0] OP_READ = 3'd0, OP_PROG = 3'd1, OP_ERASE = 3'd2,
                         OP_STAT = 3'd3, OP_ID = 3'd4, OP_RST = 3'd5,
                         OP_RAND = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_WAIT, S_DONE} st_t;
  typedef enum logic [2:0] {P_CMD1, P_ADDR, P_WDATA, P_CMD2, P_WAITRB, P_RDATA, P_END} ph_t;

  st_t st;
  ph_t ph;
  logic [2:0]     opr;
  logic [23:0]    rowr;
  logic [15:0]    colr;
  logic [LW-1:0]  lenr, dcnt;
  logic [2:0]     aidx;
  logic [1:0]     tph;
  logic [TW-1:0]  tcnt;
  logic [TOW-1:0] wcnt;
  logic [7:0]     wdreg;
  logic           errr;
  logic           rb_s1, rb_s2, rb_s3;

  function automatic ph_t after(input logic [2:0] op, input ph_t p);
    case (op)
      OP_READ:  case (p)
                  P_CMD1: return P_ADDR;   P_ADDR: return P_CMD2;
                  P_CMD2: return P_WAITRB; P_WAITRB: return P_RDATA;
                  default: return P_END;
                endcase
      OP_PROG:  case (p)
                  P_CMD1: return P_ADDR;   P_ADDR: return P_WDATA;
                  P_WDATA: return P_CMD2;  P_CMD2: return P_WAITRB;
                  default: return P_END;
                endcase
      OP_ERASE: case (p)
                  P_CMD1: return P_ADDR;   P_ADDR: return P_CMD2;
                  P_CMD2: return P_WAITRB;
                  default: return P_END;
                endcase
      OP_STAT:  return (p == P_CMD1) ? P_RDATA : P_END;
      OP_ID:    case (p)
                  P_CMD1: return P_ADDR;   P_ADDR: return P_RDATA;
                  default: return P_END;
                endcase
      OP_RST:   return (p == P_CMD1) ? P_WAITRB : P_END;
      OP_RAND:  case (p)
                  P_CMD1: return P_ADDR;   P_ADDR: return P_CMD2;
                  P_CMD2: return P_RDATA;
                  default: return P_END;
                endcase
      default:  return P_END;
    endcase
  endfunction

  function automatic logic [7:0] cmd_first(input logic [2:0] op);
    case (op)
      OP_READ:  return 8'h00;
      OP_PROG:  return 8'h80;
      OP_ERASE: return 8'h60;
      OP_STAT:  return 8'h70;
      OP_ID:    return 8'h90;
      OP_RAND:  return 8'h05;
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] cmd_second(input logic [2:0] op);
    case (op)
      OP_READ:  return 8'h30;
      OP_PROG:  return 8'h10;
      OP_ERASE: return 8'hD0;
      default:  return 8'hE0;
    endcase
  endfunction

  logic [2:0] astart, aend;
  always_comb begin
    case (opr)
      OP_ERASE: begin astart = 3'd2; aend = 3'd4; end
      OP_ID:    begin astart = 3'd5; aend = 3'd5; end
      OP_RAND:  begin astart = 3'd0; aend = 3'd1; end
      default:  begin astart = 3'd0; aend = 3'd4; end
    endcase
  end

  logic [7:0] abyte;
  always_comb begin
    case (aidx)
      3'd0: abyte = colr[7:0];
      3'd1: abyte = colr[15:8];
      3'd2: abyte = rowr[7:0];
      3'd3: abyte = rowr[15:8];
      3'd4: abyte = rowr[23:16];
      default: abyte = 8'h00;
    endcase
  end

  logic [TW-1:0] lim;
  assign lim = (tph == 2'd0) ? cfg_setup : (tph == 2'd1) ? cfg_strobe : cfg_hold;

  logic [LW-1:0] dlast;
  assign dlast = (opr == OP_STAT) ? '0 : lenr;

  logic in_bus, cyc_end, more, adv, rd_sample, rb_rise, accept;
  ph_t  tgt;
  assign in_bus    = (st == S_BUS);
  assign cyc_end   = in_bus && tph == 2'd2 && tcnt == cfg_hold;
  assign more      = (ph == P_ADDR && aidx != aend) ||
                     ((ph == P_WDATA || ph == P_RDATA) && dcnt != dlast);
  assign tgt       = after(opr, ph);
  assign adv       = (cyc_end && !more) || (st == S_WAIT && rb_flag);
  assign rd_sample = in_bus && ph == P_RDATA && tph == 2'd1 && tcnt == cfg_strobe;
  assign rb_rise   = rb_s2 && !rb_s3;
  assign accept    = req_valid && st == S_IDLE;

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign err       = errr;
  assign nf_ce_n   = (st == S_IDLE);
  assign nf_cle    = in_bus && (ph == P_CMD1 || ph == P_CMD2);
  assign nf_ale    = in_bus && ph == P_ADDR;
  assign nf_io_oe  = in_bus && ph != P_RDATA;
  assign nf_we_n   = !(nf_io_oe && tph == 2'd1);
  assign nf_re_n   = !(in_bus && ph == P_RDATA && tph == 2'd1);
  assign nf_io_out = (ph == P_CMD1) ? cmd_first(opr) :
                     (ph == P_CMD2) ? cmd_second(opr) :
                     (ph == P_ADDR) ? abyte : wdreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_s1 <= 1'b1; rb_s2 <= 1'b1; rb_s3 <= 1'b1; rb_flag <= 1'b0;
    end else begin
      rb_s1 <= nf_rb_n; rb_s2 <= rb_s1; rb_s3 <= rb_s2;
      if (rb_rise)     rb_flag <= 1'b1;
      else if (rb_clr) rb_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_END; opr <= '0; rowr <= '0; colr <= '0; lenr <= '0;
      dcnt <= '0; aidx <= '0; tph <= '0; tcnt <= '0; wcnt <= '0; wdreg <= '0;
      errr <= 1'b0; rdata <= '0; rdata_valid <= 1'b0; wdata_take <= 1'b0;
      status <= '0;
    end else begin
      rdata_valid <= 1'b0;
      wdata_take  <= 1'b0;
      if (in_bus) begin
        if (tcnt == lim) begin tph <= tph + 2'd1; tcnt <= '0; end
        else tcnt <= tcnt + 1'b1;
      end
      if (rd_sample) begin
        rdata <= nf_io_in;
        rdata_valid <= 1'b1;
        if (opr == OP_STAT) begin status <= nf_io_in; errr <= nf_io_in[0]; end
      end
      case (st)
        S_IDLE: if (accept) begin
          opr <= req_op; rowr <= req_row; colr <= req_col; lenr <= req_len;
          errr <= 1'b0; ph <= P_CMD1; tph <= '0; tcnt <= '0;
          if (req_op == 3'd7) begin st <= S_DONE; errr <= 1'b1; end
          else st <= S_BUS;
        end
        S_WAIT: if (!rb_flag) begin
          if (wcnt == cfg_timeout) begin errr <= 1'b1; st <= S_DONE; ph <= P_END; end
          else wcnt <= wcnt + 1'b1;
        end
        S_DONE: st <= S_IDLE;
        default: ;
      endcase
      if (cyc_end && more) begin
        tph <= '0; tcnt <= '0;
        if (ph == P_ADDR) aidx <= aidx + 3'd1;
        else dcnt <= dcnt + 1'b1;
        if (ph == P_WDATA) begin wdreg <= wdata; wdata_take <= 1'b1; end
      end
      if (adv) begin
        ph <= tgt; tph <= '0; tcnt <= '0; wcnt <= '0; dcnt <= '0; aidx <= astart;
        st <= (tgt == P_WAITRB) ? S_WAIT : (tgt == P_END) ? S_DONE : S_BUS;
        if (tgt == P_WDATA) begin wdreg <= wdata; wdata_take <= 1'b1; end
      end
    end
  end

  assert_oe_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_io_oe && !nf_re_n));
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));
  assert_latch_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));
  assert_ce_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> !nf_ce_n);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_clr && !rb_rise) |=> !rb_flag);
  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rb_rise |=> rb_flag);
  assert_wait_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !rb_flag) |=> (st != S_BUS));
  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy || $past(done));

endmodule

// File: tb/nand_seq_test.sv
module nand_seq_test;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req_valid = 0; logic [2:0] req_op = 0; logic [23:0] req_row = 0;
  logic [15:0] req_col = 0; logic [11:0] req_len = 0;
  logic [7:0] wdata; logic wdata_take; logic [7:0] rdata, status; logic rdata_valid;
  logic busy, done, err, rb_clr = 0, rb_flag;
  logic [3:0] cfg_setup = 1, cfg_strobe = 2, cfg_hold = 0;
  logic [15:0] cfg_timeout = 1000;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
  logic [7:0] nf_io_out, nf_io_in;
  logic nf_rb_n = 1;

  nand_seq uut (.clk, .rst_n, .req_valid, .req_op, .req_row, .req_col, .req_len,
    .wdata, .wdata_take, .rdata, .rdata_valid, .busy, .done, .err, .status,
    .cfg_setup, .cfg_strobe, .cfg_hold, .cfg_timeout, .rb_clr, .rb_flag,
    .nf_ce_n, .nf_cle, .nf_ale, .nf_we_n, .nf_re_n, .nf_io_out, .nf_io_oe,
    .nf_io_in, .nf_rb_n);

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // flash model
  logic [9:0] logb [0:255]; int logn = 0; int cmd_cyc = 0;
  logic [7:0] ab [0:7]; int ai = 0;
  logic [15:0] rd_col = 0; logic [7:0] rd_row = 0; int mode = 0; int base = 0;
  int rd_off = 0; int kicks = 0, kseen = 0, bcnt = 0, busy_len = 20;
  logic stuck = 0; logic [7:0] stat_val = 8'h40;
  logic [7:0] id_tab [0:3];
  initial begin id_tab[0] = 8'hEC; id_tab[1] = 8'hDA; id_tab[2] = 8'h10; id_tab[3] = 8'h95; end

  always @(posedge nf_we_n) if (nf_ce_n === 1'b0) begin
    logb[logn[7:0]] = {nf_cle, nf_ale, nf_io_out}; logn = logn + 1;
    if (nf_ale) begin ab[ai[2:0]] = nf_io_out; ai = ai + 1; end
    if (nf_cle) begin
      cmd_cyc = cyc;
      case (nf_io_out)
        8'h00, 8'h05, 8'h80, 8'h60, 8'h90: ai = 0;
        default: ;
      endcase
      case (nf_io_out)
        8'h30: begin rd_col = {ab[1], ab[0]}; rd_row = ab[2]; mode = 1; base = rd_off; kicks = kicks + 1; end
        8'hE0: begin rd_col = {ab[1], ab[0]}; mode = 1; base = rd_off; end
        8'h70: mode = 2;
        8'h90: begin mode = 3; base = rd_off; end
        8'h10, 8'hD0, 8'hFF: kicks = kicks + 1;
        default: ;
      endcase
    end
  end
  always @(posedge nf_re_n) if (nf_ce_n === 1'b0) rd_off = rd_off + 1;
  wire [7:0] rel = 8'(rd_off - base);
  assign nf_io_in = (mode == 1) ? 8'(rd_col[7:0] + rel + rd_row) :
                    (mode == 2) ? stat_val : (mode == 3) ? id_tab[rel[1:0]] : 8'h00;

  always @(posedge clk) begin
    if (kicks != kseen) begin kseen <= kicks; bcnt <= busy_len; nf_rb_n <= 0; end
    else if (!nf_rb_n && !stuck) begin
      if (bcnt <= 1) nf_rb_n <= 1; else bcnt <= bcnt - 1;
    end
  end

  // host write stream and read capture
  logic [7:0] wbuf [0:255]; int wptr = 0;
  always @(posedge clk) if (wdata_take) wptr <= wptr + 1;
  assign wdata = wbuf[wptr[7:0]];
  logic [7:0] rbuf [0:255]; int rn = 0;
  always @(negedge clk) if (rdata_valid) begin rbuf[rn[7:0]] = rdata; rn = rn + 1; end

  // pin timing monitor
  int wlo = 0, last_wlo = 0, rlo = 0, last_rlo = 0, oer = 0, last_oe = 0, viol = 0;
  always @(negedge clk) begin
    if (!nf_we_n) wlo = wlo + 1; else if (wlo != 0) begin last_wlo = wlo; wlo = 0; end
    if (!nf_re_n) rlo = rlo + 1; else if (rlo != 0) begin last_rlo = rlo; rlo = 0; end
    if (nf_io_oe) oer = oer + 1; else if (oer != 0) begin last_oe = oer; oer = 0; end
    if (nf_io_oe && !nf_re_n) viol = viol + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, expv); end
  endtask

  logic [9:0] expb [0:31]; int expn = 0; int log0 = 0, rn0 = 0;
  task automatic ex(input logic [9:0] v); expb[expn] = v; expn++; endtask
  task automatic cmp_log(input string tag);
    chk(logn - log0 == expn, {tag, " cycle count"}, logn - log0, expn);
    for (int k = 0; k < expn && k < logn - log0; k++)
      chk(logb[(log0 + k) % 256] == expb[k], {tag, " cycle byte"}, logb[(log0 + k) % 256], expb[k]);
  endtask

  logic got_err; int done_cyc;
  task automatic clear_flag;
    @(negedge clk) rb_clr = 1; @(negedge clk) rb_clr = 0;
  endtask
  task automatic launch(input logic [2:0] op, input logic [23:0] row, input logic [15:0] col, input logic [11:0] len);
    @(negedge clk);
    while (busy) @(negedge clk);
    log0 = logn; rn0 = rn; expn = 0;
    req_op = op; req_row = row; req_col = col; req_len = len; req_valid = 1;
    @(negedge clk) req_valid = 0;
  endtask
  task automatic finish_op(input string tag);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done, {tag, " done seen"}, done, 1);
    got_err = err; done_cyc = cyc;
  endtask

  task automatic t_reset_state;
    chk(nf_ce_n && !busy && nf_we_n && nf_re_n && !nf_io_oe && !rb_flag, "R8 idle pins after reset",
        {nf_ce_n, busy, nf_we_n, nf_re_n, nf_io_oe, rb_flag}, 6'b101100);
  endtask

  task automatic t_page_read;
    clear_flag();
    launch(3'd0, 24'h123456, 16'h0104, 12'd3);
    chk(!nf_ce_n, "R8 chip enable during op", nf_ce_n, 0);
    finish_op("R1");
    ex(10'h200); ex(10'h104); ex(10'h101); ex(10'h156); ex(10'h134); ex(10'h112); ex(10'h230);
    cmp_log("R1");
    chk(!got_err, "R1 err", got_err, 0);
    chk(rn - rn0 == 4, "R1 byte count", rn - rn0, 4);
    for (int k = 0; k < 4; k++) chk(rbuf[(rn0 + k) % 256] == 8'(8'h5A + k), "R1 read byte", rbuf[(rn0 + k) % 256], 8'h5A + k);
  endtask

  task automatic t_random;
    launch(3'd6, 24'h0, 16'h0010, 12'd1);
    finish_op("R6");
    ex(10'h205); ex(10'h110); ex(10'h100); ex(10'h2E0);
    cmp_log("R6");
    chk(rn - rn0 == 2 && rbuf[rn0 % 256] == 8'h66 && rbuf[(rn0 + 1) % 256] == 8'h67, "R6 random bytes",
        rbuf[rn0 % 256], 8'h66);
  endtask

  task automatic t_program;
    wbuf[wptr % 256] = 8'hA5; wbuf[(wptr + 1) % 256] = 8'h5A; wbuf[(wptr + 2) % 256] = 8'h3C;
    clear_flag();
    launch(3'd1, 24'h000201, 16'h0003, 12'd2);
    finish_op("R2");
    ex(10'h280); ex(10'h103); ex(10'h100); ex(10'h101); ex(10'h102); ex(10'h100);
    ex(10'h0A5); ex(10'h05A); ex(10'h03C); ex(10'h210);
    cmp_log("R2");
    chk(!got_err, "R2 err", got_err, 0);
  endtask

  task automatic t_erase;
    clear_flag();
    launch(3'd2, 24'h0A0B0C, 16'hFFFF, 12'd0);
    finish_op("R3");
    ex(10'h260); ex(10'h10C); ex(10'h10B); ex(10'h10A); ex(10'h2D0);
    cmp_log("R3");
  endtask

  task automatic t_status_timing;
    cfg_setup = 2; cfg_strobe = 3; cfg_hold = 1;
    stat_val = 8'hC1;
    launch(3'd3, 24'h0, 16'h0, 12'd5);
    finish_op("R4");
    ex(10'h270); cmp_log("R4");
    chk(status == 8'hC1, "R4 status byte", status, 8'hC1);
    chk(got_err, "R4 fail bit gives err", got_err, 1);
    chk(rn - rn0 == 1, "R4 one byte", rn - rn0, 1);
    chk(last_wlo == 4, "R7 write strobe width", last_wlo, 4);
    chk(last_rlo == 4, "R7 read strobe width", last_rlo, 4);
    chk(last_oe == 9, "R7 setup+strobe+hold span", last_oe, 9);
    stat_val = 8'h40;
    launch(3'd3, 24'h0, 16'h0, 12'd0);
    finish_op("R4");
    chk(!got_err && status == 8'h40, "R4 ready status no err", status, 8'h40);
    cfg_setup = 1; cfg_strobe = 2; cfg_hold = 0;
  endtask

  task automatic t_id;
    launch(3'd4, 24'h777777, 16'h1234, 12'd2);
    finish_op("R5");
    ex(10'h290); ex(10'h100); cmp_log("R5 id");
    chk(rn - rn0 == 3 && rbuf[rn0 % 256] == 8'hEC && rbuf[(rn0 + 2) % 256] == 8'h10, "R5 id bytes",
        rbuf[rn0 % 256], 8'hEC);
  endtask

  task automatic t_reset_op_gate;
    cfg_setup = 0; cfg_strobe = 0; cfg_hold = 0; busy_len = 30;
    clear_flag();
    launch(3'd5, 24'h0, 16'h0, 12'd0);
    repeat (5) @(negedge clk);
    req_op = 3'd3; req_valid = 1; @(negedge clk) req_valid = 0;
    finish_op("R5");
    ex(10'h2FF); cmp_log("R12 busy request ignored");
    chk(done_cyc - cmd_cyc >= 30, "R9 wait gated by ready", done_cyc - cmd_cyc, 30);
    chk(last_wlo == 1 && last_oe == 3, "R7 minimum timing", last_oe, 3);
    @(negedge clk);
    chk(!busy && !done, "R8 done single pulse", {busy, done}, 0);
    chk(rb_flag, "R9 flag set after ready", rb_flag, 1);
    clear_flag();
    chk(!rb_flag, "R9 flag cleared", rb_flag, 0);
    cfg_setup = 1; cfg_strobe = 2; busy_len = 20;
  endtask

  task automatic t_timeout;
    cfg_timeout = 40; stuck = 1;
    clear_flag();
    launch(3'd0, 24'h000001, 16'h0, 12'd3);
    finish_op("R10");
    ex(10'h200); ex(10'h100); ex(10'h100); ex(10'h101); ex(10'h100); ex(10'h100); ex(10'h230);
    cmp_log("R10");
    chk(got_err, "R10 timeout err", got_err, 1);
    repeat (3) @(negedge clk);
    chk(rn - rn0 == 0, "R10 no read data", rn - rn0, 0);
    stuck = 0; cfg_timeout = 1000;
    repeat (30) @(negedge clk);
    clear_flag();
  endtask

  task automatic t_bad_op;
    launch(3'd7, 24'h0, 16'h0, 12'd0);
    finish_op("R12");
    chk(got_err, "R12 bad op err", got_err, 1);
    cmp_log("R12 bad op no bus");
  endtask

  initial begin
    #300000;
    errors++; checks++;
    $display("FAIL watchdog R8 actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_page_read();
    t_random();
    t_program();
    t_erase();
    t_status_timing();
    t_id();
    t_reset_op_gate();
    t_timeout();
    t_bad_op();
    chk(viol == 0, "R11 oe never with read strobe", viol, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule